// File: doc/BRIEF.md
# PC-Relative Address Generation Unit

This block produces the two addresses a small 16-bit processor needs for each instruction: the value the program counter takes next, and the address presented to memory. It works from the instruction word, the program counter as it stands after fetch has already added one, a base register value that the register file reads for the instruction, the live negative/zero/positive flags, and the value on the processor bus. Offsets carried in the instruction are sign-extended and added either to the incremented program counter or to the base register. A trap vector taken from the low byte of the instruction is zero-extended.

Conditional branches are resolved inside the block. The three mask bits in the instruction are ANDed with the live flags, and the branch is taken if any of the resulting terms is set. A register jump loads the base register value into the program counter. A trap loads the program counter from the bus. For the load-effective-address instruction, the memory address output is the value written back, and no memory access is requested. All outputs are registered once, so each result appears one clock after its inputs are sampled.

Top module: `pcrel_agu`

## Requirements
- R1: While rst_ni is low, next_pc_o, mem_addr_o, mem_en_o and br_taken_o are all zero. The reset is asynchronous.
- R2: The opcode is instr_i[15:12]. The mask bits are n = instr_i[11], z = instr_i[10] and p = instr_i[9]. The flags are flags_i = {n, z, p} on bits 2, 1 and 0. For opcode 0000, when (mask AND flags) is nonzero, br_taken_o is 1 and next_pc_o = pc_inc_i + sign-extended instr_i[8:0].
- R3: For opcode 0000 with no matching flag, next_pc_o = pc_inc_i and br_taken_o = 0. This includes a mask of 000.
- R4: For opcodes 0000, 0010, 0011, 1010, 1011 and 1110, and for every opcode not listed in R5 to R7, mem_addr_o = pc_inc_i + sign-extended instr_i[8:0]. This covers offsets from -256 to +255.
- R5: For opcodes 0110 and 0111, mem_addr_o = base_i + sign-extended instr_i[5:0].
- R6: For opcode 1100, next_pc_o = base_i, mem_addr_o = base_i, br_taken_o = 0 and mem_en_o = 0.
- R7: For opcode 1111, next_pc_o = bus_i, mem_addr_o = zero-extended instr_i[7:0], and mem_en_o = 1.
- R8: For opcode 1110, mem_en_o = 0 and mem_addr_o carries the computed address to write back. mem_en_o is 1 only for opcodes 0010, 0011, 0110, 0111, 1010, 1011 and 1111.
- R9: For opcodes other than 0000, 1100 and 1111, next_pc_o = pc_inc_i and br_taken_o = 0.
- R10: All address sums wrap modulo 2^16.
- R11: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| pc_inc_i | input | 16 | Program counter after the fetch increment |
| base_i | input | 16 | Register value used as base or jump target |
| flags_i | input | 3 | Live flags {n, z, p} |
| bus_i | input | 16 | Bus value used as the trap target |
| next_pc_o | output | 16 | Next program counter |
| mem_addr_o | output | 16 | Memory address or effective address |
| mem_en_o | output | 1 | Memory access requested |
| br_taken_o | output | 1 | Conditional branch taken |

## Verification
The bench builds the block with its default widths: a 16-bit data path, a 9-bit PC-relative offset, a 6-bit base offset and an 8-bit trap vector. At these widths a PC near the top of memory combined with the +255 offset wraps past zero, and a PC near the bottom combined with the -256 offset wraps below zero, so R10 is exercised at both extremes of the offset field. The 3-bit flag width allows every mask case to be tested: a single matching flag, a full mask against any flag, a mask that matches no flag, and an empty mask.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    OPC_BR   = 4'b0000,
    OPC_LD   = 4'b0010,
    OPC_ST   = 4'b0011,
    OPC_LDR  = 4'b0110,
    OPC_STR  = 4'b0111,
    OPC_LDI  = 4'b1010,
    OPC_STI  = 4'b1011,
    OPC_JMP  = 4'b1100,
    OPC_LEA  = 4'b1110,
    OPC_TRAP = 4'b1111
  } opc_e;

  typedef enum logic [1:0] {PCS_SEQ, PCS_ADDER, PCS_BUS} pc_sel_e;
  typedef enum logic [1:0] {OFS_PC, OFS_BASE, OFS_ZERO} ofs_sel_e;

  typedef struct packed {
    pc_sel_e  pc_sel;
    logic     is_br;
    logic     use_base;
    ofs_sel_e ofs_sel;
    logic     addr_vec;
    logic     mem_en;
  } ctrl_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [3:0] opcode_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o = '{pc_sel: PCS_SEQ, is_br: 1'b0, use_base: 1'b0,
               ofs_sel: OFS_PC, addr_vec: 1'b0, mem_en: 1'b0};
    unique case (opcode_i)
      OPC_BR:   begin ctrl_o.pc_sel = PCS_ADDER; ctrl_o.is_br = 1'b1; end
      OPC_LD, OPC_ST, OPC_LDI, OPC_STI: ctrl_o.mem_en = 1'b1;
      OPC_LDR, OPC_STR: begin
        ctrl_o.use_base = 1'b1;
        ctrl_o.ofs_sel  = OFS_BASE;
        ctrl_o.mem_en   = 1'b1;
      end
      OPC_JMP: begin
        ctrl_o.pc_sel   = PCS_ADDER;
        ctrl_o.use_base = 1'b1;
        ctrl_o.ofs_sel  = OFS_ZERO;
      end
      OPC_TRAP: begin
        ctrl_o.pc_sel   = PCS_BUS;
        ctrl_o.addr_vec = 1'b1;
        ctrl_o.mem_en   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/agu_cond.sv
module agu_cond #(
  parameter int FLAG_W = 3
) (
  input  logic [FLAG_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              taken_o
);

  logic [FLAG_W-1:0] hit;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_hit
    assign hit[g] = mask_i[g] & flags_i[g];
  end

  assign taken_o = |hit;

endmodule

// File: rtl/agu_adder.sv
module agu_adder
  import agu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PCOFS_W = 9,
  parameter int BOFS_W  = 6
) (
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  base_i,
  input  logic [PCOFS_W-1:0] ofs_field_i,
  input  logic               use_base_i,
  input  ofs_sel_e           ofs_sel_i,
  output logic [DATA_W-1:0]  sum_o
);

  localparam int PC_PAD = DATA_W - PCOFS_W;
  localparam int B_PAD  = DATA_W - BOFS_W;

  logic [DATA_W-1:0] ofs_pc, ofs_base, ofs, opnd;

  assign ofs_pc   = {{PC_PAD{ofs_field_i[PCOFS_W-1]}}, ofs_field_i};
  assign ofs_base = {{B_PAD{ofs_field_i[BOFS_W-1]}}, ofs_field_i[BOFS_W-1:0]};

  always_comb begin
    unique case (ofs_sel_i)
      OFS_BASE: ofs = ofs_base;
      OFS_ZERO: ofs = '0;
      default:  ofs = ofs_pc;
    endcase
  end

  assign opnd  = use_base_i ? base_i : pc_i;
  assign sum_o = opnd + ofs;  // wraps modulo 2^DATA_W

endmodule

// File: rtl/pcrel_agu.sv
module pcrel_agu
  import agu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PCOFS_W = 9,
  parameter int BOFS_W  = 6,
  parameter int VEC_W   = 8,
  parameter int FLAG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] pc_inc_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] next_pc_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              mem_en_o,
  output logic              br_taken_o
);

  localparam int OPC_LSB  = DATA_W - 4;
  localparam int MASK_LSB = PCOFS_W;

  ctrl_t             ctrl;
  logic              cond_hit;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] vec_zext;
  logic [DATA_W-1:0] next_pc_d, mem_addr_d;
  logic              taken_d;

  agu_decode u_dec (
    .opcode_i (instr_i[OPC_LSB +: 4]),
    .ctrl_o   (ctrl)
  );

  agu_cond #(.FLAG_W(FLAG_W)) u_cond (
    .mask_i  (instr_i[MASK_LSB +: FLAG_W]),
    .flags_i (flags_i),
    .taken_o (cond_hit)
  );

  agu_adder #(.DATA_W(DATA_W), .PCOFS_W(PCOFS_W), .BOFS_W(BOFS_W)) u_add (
    .pc_i        (pc_inc_i),
    .base_i      (base_i),
    .ofs_field_i (instr_i[PCOFS_W-1:0]),
    .use_base_i  (ctrl.use_base),
    .ofs_sel_i   (ctrl.ofs_sel),
    .sum_o       (sum)
  );

  assign vec_zext = {{(DATA_W-VEC_W){1'b0}}, instr_i[VEC_W-1:0]};
  assign taken_d  = ctrl.is_br & cond_hit;

  always_comb begin
    unique case (ctrl.pc_sel)
      PCS_ADDER: next_pc_d = (ctrl.is_br && !cond_hit) ? pc_inc_i : sum;
      PCS_BUS:   next_pc_d = bus_i;
      default:   next_pc_d = pc_inc_i;
    endcase
  end

  assign mem_addr_d = ctrl.addr_vec ? vec_zext : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o  <= '0;
      mem_addr_o <= '0;
      mem_en_o   <= 1'b0;
      br_taken_o <= 1'b0;
    end else begin
      next_pc_o  <= next_pc_d;
      mem_addr_o <= mem_addr_d;
      mem_en_o   <= ctrl.mem_en;
      br_taken_o <= taken_d;
    end
  end

endmodule

// File: rtl/pcrel_agu_chk.sv
module pcrel_agu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] instr_i,
  input logic [DATA_W-1:0] pc_inc_i,
  input logic [DATA_W-1:0] base_i,
  input logic [2:0]        flags_i,
  input logic [DATA_W-1:0] bus_i,
  input logic [DATA_W-1:0] next_pc_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic              mem_en_o,
  input logic              br_taken_o
);

  logic [3:0]        op;
  logic [DATA_W-1:0] s9, s6, v8;
  logic              match, pcrel_op, base_op;

  assign op       = instr_i[DATA_W-1 -: 4];
  assign s9       = {{(DATA_W-9){instr_i[8]}}, instr_i[8:0]};
  assign s6       = {{(DATA_W-6){instr_i[5]}}, instr_i[5:0]};
  assign v8       = {{(DATA_W-8){1'b0}}, instr_i[7:0]};
  assign match    = (instr_i[11] & flags_i[2]) | (instr_i[10] & flags_i[1]) |
                    (instr_i[9] & flags_i[0]);
  assign pcrel_op = (op == 4'h0) || (op == 4'h2) || (op == 4'h3) ||
                    (op == 4'hA) || (op == 4'hB) || (op == 4'hE);
  assign base_op  = (op == 4'h6) || (op == 4'h7);

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (next_pc_o == '0 && mem_addr_o == '0 && !mem_en_o && !br_taken_o));

  p_br_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'h0 && match) |=> (br_taken_o && next_pc_o == $past(pc_inc_i + s9)));

  p_br_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'h0 && !match) |=> (!br_taken_o && next_pc_o == $past(pc_inc_i)));

  p_pcrel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcrel_op |=> (mem_addr_o == $past(pc_inc_i + s9)));

  p_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_op |=> (mem_addr_o == $past(base_i + s6) && mem_en_o));

  p_jmp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'hC) |=> (next_pc_o == $past(base_i) && !br_taken_o && !mem_en_o));

  p_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'hF) |=> (next_pc_o == $past(bus_i) && mem_addr_o == $past(v8) && mem_en_o));

  p_lea_nomem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'hE) |=> !mem_en_o);

  p_seq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 4'h0 && op != 4'hC && op != 4'hF) |=> (next_pc_o == $past(pc_inc_i) && !br_taken_o));

endmodule

bind pcrel_agu pcrel_agu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_i    (instr_i),
  .pc_inc_i   (pc_inc_i),
  .base_i     (base_i),
  .flags_i    (flags_i),
  .bus_i      (bus_i),
  .next_pc_o  (next_pc_o),
  .mem_addr_o (mem_addr_o),
  .mem_en_o   (mem_en_o),
  .br_taken_o (br_taken_o)
);

// File: tb/sim_pcrel_agu.sv
module sim_pcrel_agu;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] pc;
    logic [15:0] base;
    logic [2:0]  flags;
    logic [15:0] bus;
    logic [15:0] exp_pc;
    logic [15:0] exp_addr;
    logic        exp_mem;
    logic        exp_tk;
    logic [7:0]  req;
  } vec_t;

  // instr, pc_inc, base, flags, bus, next_pc, mem_addr, mem_en, taken, requirement
  localparam vec_t VECS [NV] = '{
    '{16'h0405, 16'h3005, 16'h0000, 3'b010, 16'h0000, 16'h300A, 16'h300A, 1'b0, 1'b1, 8'd2}, // R2 single flag
    '{16'h0FFA, 16'h300A, 16'h0000, 3'b001, 16'h0000, 16'h3004, 16'h3004, 1'b0, 1'b1, 8'd2}, // R2 full mask, backward
    '{16'h0405, 16'h3005, 16'h0000, 3'b001, 16'h0000, 16'h3005, 16'h300A, 1'b0, 1'b0, 8'd3}, // R3 no match
    '{16'h0005, 16'h3005, 16'h0000, 3'b100, 16'h0000, 16'h3005, 16'h300A, 1'b0, 1'b0, 8'd3}, // R3 empty mask
    '{16'hE3FD, 16'h30F7, 16'h0000, 3'b001, 16'h0000, 16'h30F7, 16'h30F4, 1'b0, 1'b0, 8'd8}, // R8 effective address
    '{16'h35FB, 16'h30F9, 16'h0000, 3'b001, 16'h0000, 16'h30F9, 16'h30F4, 1'b1, 1'b0, 8'd4}, // R4 store pc-rel
    '{16'h744E, 16'h30FC, 16'h30F4, 3'b001, 16'h0000, 16'h30FC, 16'h3102, 1'b1, 1'b0, 8'd5}, // R5 positive offset
    '{16'h683F, 16'h1000, 16'h4000, 3'b100, 16'h0000, 16'h1000, 16'h3FFF, 1'b1, 1'b0, 8'd5}, // R5 negative offset
    '{16'hC1C0, 16'h2222, 16'h1234, 3'b111, 16'h0000, 16'h1234, 16'h1234, 1'b0, 1'b0, 8'd6}, // R6 jump
    '{16'hF025, 16'h3012, 16'h0000, 3'b010, 16'h0520, 16'h0520, 16'h0025, 1'b1, 1'b0, 8'd7}, // R7 trap
    '{16'h20FF, 16'hFF80, 16'h0000, 3'b010, 16'h0000, 16'hFF80, 16'h007F, 1'b1, 1'b0, 8'd10}, // R10 +255 wraps up
    '{16'hA100, 16'h0010, 16'h0000, 3'b010, 16'h0000, 16'h0010, 16'hFF10, 1'b1, 1'b0, 8'd10}, // R10 -256 wraps down
    '{16'h1261, 16'h2000, 16'h5555, 3'b111, 16'hFFFF, 16'h2000, 16'h2061, 1'b0, 1'b0, 8'd9}   // R9 other opcode
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0, pc_inc_i = '0, base_i = '0, bus_i = '0;
  logic [2:0]  flags_i = '0;
  logic [15:0] next_pc_o, mem_addr_o;
  logic        mem_en_o, br_taken_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pcrel_agu u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .instr_i    (instr_i),
    .pc_inc_i   (pc_inc_i),
    .base_i     (base_i),
    .flags_i    (flags_i),
    .bus_i      (bus_i),
    .next_pc_o  (next_pc_o),
    .mem_addr_o (mem_addr_o),
    .mem_en_o   (mem_en_o),
    .br_taken_o (br_taken_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    instr_i  = v.instr;
    pc_inc_i = v.pc;
    base_i   = v.base;
    flags_i  = v.flags;
    bus_i    = v.bus;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state with busy inputs
    drive(VECS[9]);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 next_pc", next_pc_o, 16'h0);
    chk("R1 mem_addr", mem_addr_o, 16'h0);
    chk("R1 mem_en", {15'h0, mem_en_o}, 16'h0);
    chk("R1 taken", {15'h0, br_taken_o}, 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      @(posedge clk_i);
      @(negedge clk_i);
      chk($sformatf("R%0d v%0d next_pc", VECS[i].req, i), next_pc_o, VECS[i].exp_pc);
      chk($sformatf("R%0d v%0d mem_addr", VECS[i].req, i), mem_addr_o, VECS[i].exp_addr);
      chk($sformatf("R%0d v%0d mem_en", VECS[i].req, i), {15'h0, mem_en_o}, {15'h0, VECS[i].exp_mem});
      chk($sformatf("R%0d v%0d taken", VECS[i].req, i), {15'h0, br_taken_o}, {15'h0, VECS[i].exp_tk});
    end

    // R11: a new input has no effect until the next rising edge
    drive(VECS[8]);
    #1;
    chk("R11 hold next_pc", next_pc_o, 16'h2000);
    chk("R11 hold mem_addr", mem_addr_o, 16'h2061);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R11 update next_pc", next_pc_o, 16'h1234);

    // R6: jump ignores the flags and the branch mask bits
    instr_i = 16'hCFC0;
    flags_i = 3'b000;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 jump no flags", next_pc_o, 16'h1234);
    chk("R6 jump taken low", {15'h0, br_taken_o}, 16'h0);

    // R1: asynchronous reset clears outputs mid-cycle
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async next_pc", next_pc_o, 16'h0);
    chk("R1 async mem_addr", mem_addr_o, 16'h0);
    finish_run();
  end

  initial begin
    repeat (2000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

endmodule